// File: doc/BRIEF.md
# Chainable Trigger Timer

An up-counting timer meant to sit in a network of timers and converters. A clock prescaler feeds a counter that wraps at a programmable reload value. Every wrap produces a one-cycle update event. The reload value can be double-buffered, so a new value only takes effect at an update event. A software strobe forces an update at once.

A slave controller links the counter to one of four external trigger inputs, picked by a 2-bit select. The chosen trigger can gate the count, start it, restart it, or act as its clock. A master selector chooses which internal event drives the single trigger output. That output can then be wired to the trigger input of another timer or to a converter's start input.

Software reaches the registers through a plain write/read port. Writes are synchronous and reads are combinational.

Top module: `chain_timer`

## Requirements
- R1: After reset, the counter is 0, the trigger output is 0, the control, mode and prescaler registers read 0, and the reload register reads all ones.
- R2: Register map on `addr_i`:
  - 0 is control: bit0 run, bit1 reload preload enable.
  - 1 is mode: bits [2:0] slave mode, bits [5:3] master mode, bits [7:6] trigger select.
  - 2 is prescaler.
  - 3 is reload.
  - 4 is the strobe, write-only, acting on bit0.
  - 5 is the counter value, read-only.
  - 8+k is compare register k, for k = 0..3.
  - Written registers read back unchanged.
- R3: With slave mode 0 and run set, the counter advances once every prescaler+1 clocks. It wraps from the reload value to 0 with an update event, so the update period is (prescaler+1)·(reload+1) clocks. The prescaler value is taken only at an update event.
- R4: With preload enabled, a reload write takes effect at the next update event. With preload disabled, it takes effect at once.
- R5: Writing the strobe register with bit0=1 clears the counter and the prescaler, loads the buffered values and raises an update event. Writing it with bit0=0 has no effect.
- R6: Only the trigger input picked by the select field affects the counter. Each input passes through two synchronising flops before edge detection.
- R7: Gated mode (slave 5) advances the counter on exactly as many clocks as the selected trigger was high. When the trigger goes low, the counter holds its value and is not cleared.
- R8: Trigger-start mode (slave 6) sets the run bit on a rising trigger edge, 3 clocks after the input changes. The counter is not cleared.
- R9: Reset mode (slave 4): a rising trigger edge clears the counter and raises an update event. The counter reads 0 and the output is high 3 clocks after the input rises, in master mode 2.
- R10: External-clock mode (slave 7) advances the counter once per rising edge of the selected trigger while run is set. It does not advance otherwise.
- R11: Slave codes 1, 2 and 3 are reserved for an external quadrature counter and hold the counter still.
- R12: The trigger output is a register, loaded one clock after its source:
  - Master 0 follows the strobe write.
  - Master 1 follows the run bit.
  - Master 2 follows the update event.
- R13: Master 3 pulses the output for one clock in the first cycle in which the counter equals compare register 0.
- R14: Masters 4..7 output "counter below compare register k" for k = 0..3, delayed by one clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register address for reads and writes |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Combinational read data at addr_i |
| trig_i | input | N_TRIG | Asynchronous trigger inputs |
| trgo_o | output | 1 | Trigger output for chaining |
| count_o | output | CNT_W | Current counter value |

## Verification
The three kinds of wrong internal state each show up at the ports in a set number of cycles:
- A wrong prescaler or reload shadow changes the spacing of output pulses in update mode. This is visible within one period, and the bench measures that spacing exactly over a sweep of prescaler and reload values.
- A slave controller that is wrong about the level or the edge moves `count_o` away from an exact count. Windows of known length are driven, so one clock too many or too few shows as a wrong count after the synchroniser's three-cycle delay.
- A wrong master source or compare reference shows on `trgo_o` in the clock after the counter value that should have produced it.

// File: rtl/ct_pkg.sv
package ct_pkg;
  typedef enum logic [2:0] {
    SM_OFF     = 3'd0,
    SM_ENC_A   = 3'd1,
    SM_ENC_B   = 3'd2,
    SM_ENC_AB  = 3'd3,
    SM_RESET   = 3'd4,
    SM_GATED   = 3'd5,
    SM_START   = 3'd6,
    SM_EXTCLK  = 3'd7
  } slave_mode_e;

  typedef enum logic [2:0] {
    MM_STROBE  = 3'd0,
    MM_ENABLE  = 3'd1,
    MM_UPDATE  = 3'd2,
    MM_CMPHIT  = 3'd3,
    MM_CREF0   = 3'd4,
    MM_CREF1   = 3'd5,
    MM_CREF2   = 3'd6,
    MM_CREF3   = 3'd7
  } master_mode_e;

  localparam int N_CMP    = 4;
  localparam int A_CTRL   = 0;
  localparam int A_MODE   = 1;
  localparam int A_PSC    = 2;
  localparam int A_RELOAD = 3;
  localparam int A_STROBE = 4;
  localparam int A_COUNT  = 5;
  localparam int A_CMP0   = 8;
endpackage

// File: rtl/ct_trig_in.sv
module ct_trig_in #(
  parameter int N_TRIG = 4,
  localparam int SEL_W = (N_TRIG > 1) ? $clog2(N_TRIG) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_TRIG-1:0] trig_i,
  input  logic [SEL_W-1:0]  sel_i,
  output logic              lvl_o,
  output logic              rise_o
);
  logic [N_TRIG-1:0] s1_q, s2_q;
  logic              prev_q;

  for (genvar g = 0; g < N_TRIG; g++) begin : g_sync
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q[g] <= 1'b0;
        s2_q[g] <= 1'b0;
      end else begin
        s1_q[g] <= trig_i[g];
        s2_q[g] <= s1_q[g];
      end
    end
  end

  assign lvl_o = s2_q[sel_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_o;
  end

  // a select change can show as one edge; the select is programmed before use
  assign rise_o = lvl_o & ~prev_q;
endmodule

// File: rtl/ct_slave_ctrl.sv
module ct_slave_ctrl
  import ct_pkg::*;
(
  input  slave_mode_e mode_i,
  input  logic        run_i,
  input  logic        lvl_i,
  input  logic        rise_i,
  output logic        tick_o,
  output logic        restart_o,
  output logic        start_o
);
  always_comb begin
    tick_o    = 1'b0;
    restart_o = 1'b0;
    start_o   = 1'b0;
    unique case (mode_i)
      SM_OFF:    tick_o = run_i;
      SM_RESET:  begin tick_o = run_i; restart_o = rise_i; end
      SM_GATED:  tick_o = run_i & lvl_i;
      SM_START:  begin tick_o = run_i; start_o = rise_i; end
      SM_EXTCLK: tick_o = run_i & rise_i;
      default:   tick_o = 1'b0; // quadrature codes: counted elsewhere
    endcase
  end
endmodule

// File: rtl/ct_count_core.sv
module ct_count_core #(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             restart_i,
  input  logic             preload_i,
  input  logic [PSC_W-1:0] psc_i,
  input  logic [CNT_W-1:0] arr_i,
  input  logic [CNT_W-1:0] cmp0_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             uev_o,
  output logic             hit_o
);
  logic [PSC_W-1:0] pcnt_q, psc_sh_q;
  logic [CNT_W-1:0] cnt_q, arr_sh_q, arr_eff, cnt_nxt;
  logic             pwrap, ovf;

  assign arr_eff = preload_i ? arr_sh_q : arr_i;
  assign pwrap   = tick_i && (pcnt_q == psc_sh_q);
  assign ovf     = pwrap && (cnt_q == arr_eff);
  assign cnt_nxt = ovf ? '0 : cnt_q + 1'b1;
  assign uev_o   = restart_i | ovf;
  assign hit_o   = pwrap & ~restart_i & (cnt_nxt == cmp0_i);
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pcnt_q <= '0;
      cnt_q  <= '0;
    end else if (restart_i) begin
      pcnt_q <= '0;
      cnt_q  <= '0;
    end else if (tick_i) begin
      if (pwrap) begin
        pcnt_q <= '0;
        cnt_q  <= cnt_nxt;
      end else begin
        pcnt_q <= pcnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psc_sh_q <= '0;
      arr_sh_q <= '1;
    end else if (uev_o) begin
      psc_sh_q <= psc_i;
      arr_sh_q <= arr_i;
    end
  end
endmodule

// File: rtl/ct_trgo_sel.sv
module ct_trgo_sel
  import ct_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  master_mode_e                mode_i,
  input  logic                        strobe_i,
  input  logic                        run_i,
  input  logic                        uev_i,
  input  logic                        hit_i,
  input  logic [CNT_W-1:0]            cnt_i,
  input  logic [N_CMP-1:0][CNT_W-1:0] cmp_i,
  output logic                        trgo_o
);
  logic [N_CMP-1:0] cref;
  logic             src;

  for (genvar k = 0; k < N_CMP; k++) begin : g_cref
    assign cref[k] = cnt_i < cmp_i[k];
  end

  always_comb begin
    unique case (mode_i)
      MM_STROBE: src = strobe_i;
      MM_ENABLE: src = run_i;
      MM_UPDATE: src = uev_i;
      MM_CMPHIT: src = hit_i;
      default:   src = cref[mode_i[1:0]];
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trgo_o <= 1'b0;
    else         trgo_o <= src;
  end
endmodule

// File: rtl/chain_timer.sv
module chain_timer
  import ct_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 16,
  parameter int N_TRIG = 4,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  localparam int SEL_W = (N_TRIG > 1) ? $clog2(N_TRIG) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [N_TRIG-1:0] trig_i,
  output logic              trgo_o,
  output logic [CNT_W-1:0]  count_o
);
  localparam int SEL_LSB = 6;

  logic                        run_q, pre_q;
  slave_mode_e                 slave_q;
  master_mode_e                master_q;
  logic [SEL_W-1:0]            sel_q;
  logic [PSC_W-1:0]            psc_q;
  logic [CNT_W-1:0]            arr_q;
  logic [N_CMP-1:0][CNT_W-1:0] cmp_q;

  logic wr_ctrl, wr_mode, ug;
  logic lvl, rise, tick, slv_restart, start, uev, hit;

  assign wr_ctrl = wr_en_i && (addr_i == ADDR_W'(A_CTRL));
  assign wr_mode = wr_en_i && (addr_i == ADDR_W'(A_MODE));
  assign ug      = wr_en_i && (addr_i == ADDR_W'(A_STROBE)) && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q    <= 1'b0;
      pre_q    <= 1'b0;
      slave_q  <= SM_OFF;
      master_q <= MM_STROBE;
      sel_q    <= '0;
      psc_q    <= '0;
      arr_q    <= '1;
    end else begin
      if (wr_ctrl) begin
        run_q <= wdata_i[0];
        pre_q <= wdata_i[1];
      end else if (start) begin
        run_q <= 1'b1;
      end
      if (wr_mode) begin
        slave_q  <= slave_mode_e'(wdata_i[2:0]);
        master_q <= master_mode_e'(wdata_i[5:3]);
        sel_q    <= wdata_i[SEL_LSB +: SEL_W];
      end
      if (wr_en_i && addr_i == ADDR_W'(A_PSC))    psc_q <= wdata_i[PSC_W-1:0];
      if (wr_en_i && addr_i == ADDR_W'(A_RELOAD)) arr_q <= wdata_i[CNT_W-1:0];
    end
  end

  for (genvar k = 0; k < N_CMP; k++) begin : g_cmp
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cmp_q[k] <= '0;
      else if (wr_en_i && addr_i == ADDR_W'(A_CMP0 + k)) cmp_q[k] <= wdata_i[CNT_W-1:0];
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_W'(A_CTRL):   rdata_o = DATA_W'({pre_q, run_q});
      ADDR_W'(A_MODE):   rdata_o = DATA_W'({sel_q, master_q, slave_q});
      ADDR_W'(A_PSC):    rdata_o = DATA_W'(psc_q);
      ADDR_W'(A_RELOAD): rdata_o = DATA_W'(arr_q);
      ADDR_W'(A_COUNT):  rdata_o = DATA_W'(count_o);
      default: begin
        for (int k = 0; k < N_CMP; k++)
          if (addr_i == ADDR_W'(A_CMP0 + k)) rdata_o = DATA_W'(cmp_q[k]);
      end
    endcase
  end

  ct_trig_in #(.N_TRIG(N_TRIG)) u_trig (
    .clk_i(clk_i), .rst_ni(rst_ni), .trig_i(trig_i), .sel_i(sel_q),
    .lvl_o(lvl), .rise_o(rise)
  );

  ct_slave_ctrl u_slave (
    .mode_i(slave_q), .run_i(run_q), .lvl_i(lvl), .rise_i(rise),
    .tick_o(tick), .restart_o(slv_restart), .start_o(start)
  );

  ct_count_core #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick),
    .restart_i(ug | slv_restart), .preload_i(pre_q),
    .psc_i(psc_q), .arr_i(arr_q), .cmp0_i(cmp_q[0]),
    .cnt_o(count_o), .uev_o(uev), .hit_o(hit)
  );

  ct_trgo_sel #(.CNT_W(CNT_W)) u_trgo (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(master_q), .strobe_i(ug),
    .run_i(run_q), .uev_i(uev), .hit_i(hit), .cnt_i(count_o),
    .cmp_i(cmp_q), .trgo_o(trgo_o)
  );
endmodule

// File: rtl/ct_checker.sv
module ct_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [CNT_W-1:0] count_o,
  input logic             trgo_o,
  input logic [2:0]       slave_i,
  input logic [2:0]       master_i,
  input logic             ug_i,
  input logic             uev_i,
  input logic             lvl_i,
  input logic             rise_i,
  input logic             run_i,
  input logic             wr_ctrl_i
);
  p_strobe_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ug_i |=> (count_o == '0));

  p_update_to_trgo_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uev_i && master_i == 3'd2) |=> trgo_o);

  p_quad_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slave_i inside {3'd1, 3'd2, 3'd3} && !ug_i) |=> $stable(count_o));

  p_gate_low_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slave_i == 3'd5 && !lvl_i && !ug_i) |=> $stable(count_o));

  p_start_sets_run_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slave_i == 3'd6 && rise_i && !wr_ctrl_i) |=> run_i);

  p_edge_restart_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slave_i == 3'd4 && rise_i) |=> (count_o == '0));

  p_extclk_no_edge_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slave_i == 3'd7 && !rise_i && !ug_i) |=> $stable(count_o));
endmodule

bind chain_timer ct_checker #(.CNT_W(CNT_W)) u_ct_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .count_o(count_o), .trgo_o(trgo_o),
  .slave_i(slave_q), .master_i(master_q), .ug_i(ug), .uev_i(uev),
  .lvl_i(lvl), .rise_i(rise), .run_i(run_q), .wr_ctrl_i(wr_ctrl)
);

// File: tb/tb_chain_timer.sv
module tb_chain_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic [3:0]  trig_i = '0;
  logic        trgo_o;
  logic [15:0] count_o;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  chain_timer dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .trig_i(trig_i),
    .trgo_o(trgo_o), .count_o(count_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    addr_i = a;
    #1;
    d = rdata_o;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_pulse();
    int n = 0;
    while (!trgo_o && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic gap(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!trgo_o && n < 5000);
  endtask

  initial begin
    #(4 * 150000);
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] d, c0, c1;
    int g, n, pulses, bad;
    logic [15:0] cmpv [4];
    cmpv[0] = 2; cmpv[1] = 3; cmpv[2] = 5; cmpv[3] = 6;

    idle(5);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    chk("R1 count", count_o, 0);
    chk("R1 trgo", trgo_o, 0);
    rd(3, d); chk("R1 reload", d, 16'hFFFF);
    rd(1, d); chk("R1 mode", d, 0);
    rd(0, d); chk("R1 ctrl", d, 0);
    rd(2, d); chk("R1 psc", d, 0);

    // R2 register map readback
    wr(2, 16'h1234); rd(2, d); chk("R2 psc", d, 16'h1234);
    wr(10, 16'h0055); rd(10, d); chk("R2 cmp2", d, 16'h0055);
    wr(1, 16'h00D5); rd(1, d); chk("R2 mode", d, 16'h00D5);
    rd(5, d); chk("R2 count reg", d, count_o);
    wr(2, 0);

    // R3 / R12 period sweep, update-event output
    wr(1, 2 << 3);
    wr(0, 1);
    for (int p = 0; p < 4; p++) begin
      for (int a = 0; a < 6; a++) begin
        wr(2, 16'(p));
        wr(3, 16'(a));
        wr(4, 1);
        wait_pulse();
        gap(g);
        chk($sformatf("R3 R12 period psc=%0d rl=%0d", p, a), g, (p + 1) * (a + 1));
      end
    end
    wr(2, 0);

    // R4 preload enabled: old reload finishes the period
    wr(0, 3);
    wr(3, 9);
    wr(4, 1);
    wait_pulse();
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (n == 2) begin wr_en_i = 1'b1; addr_i = 3; wdata_i = 3; end
      else wr_en_i = 1'b0;
    end while (!trgo_o && n < 100);
    chk("R4 preload old period", n, 10);
    gap(g);
    chk("R4 preload new period", g, 4);

    // R4 preload disabled: immediate
    wr(0, 1);
    wr(3, 9);
    wr(4, 1);
    wait_pulse();
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (n == 1) begin wr_en_i = 1'b1; addr_i = 3; wdata_i = 3; end
      else wr_en_i = 1'b0;
    end while (!trgo_o && n < 100);
    chk("R4 immediate reload", n, 4);

    // R5 strobe, R12 master 0
    wr(1, 0);
    wr(3, 200);
    wr(4, 1);
    idle(20);
    wr(4, 1);
    chk("R5 strobe clears", count_o, 0);
    chk("R12 strobe source", trgo_o, 1);
    @(negedge clk);
    chk("R5 counts after strobe", count_o, 1);
    chk("R12 strobe one cycle", trgo_o, 0);
    c0 = count_o;
    wr(4, 0);
    chk("R5 bit0 clear ignored", count_o, c0 + 2);
    chk("R5 no strobe output", trgo_o, 0);

    // R12 master 1 follows run
    wr(1, 1 << 3);
    wr(0, 0);
    idle(2);
    chk("R12 enable low", trgo_o, 0);
    wr(0, 1);
    chk("R12 enable lag", trgo_o, 0);
    @(negedge clk);
    chk("R12 enable high", trgo_o, 1);

    // R13 compare pulse
    wr(1, 3 << 3);
    wr(3, 9);
    wr(8, 4);
    wr(4, 1);
    pulses = 0; bad = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (trgo_o) begin
        pulses++;
        if (count_o != 4) bad++;
      end
    end
    chk("R13 pulse count", pulses, 3);
    chk("R13 pulse at match", bad, 0);

    // R14 compare references
    for (int k = 0; k < 4; k++) wr(4'(8 + k), cmpv[k]);
    wr(3, 7);
    for (int k = 0; k < 4; k++) begin
      wr(1, 16'((4 + k) << 3));
      idle(2);
      bad = 0;
      for (int i = 0; i < 16; i++) begin
        c0 = count_o;
        @(negedge clk);
        if (trgo_o !== (c0 < cmpv[k])) bad++;
      end
      chk($sformatf("R14 ref%0d mismatches", k), bad, 0);
    end

    // R11 quadrature codes hold
    wr(3, 200);
    wr(0, 1);
    for (int e = 1; e < 4; e++) begin
      wr(1, 16'((2 << 3) | e));
      c0 = count_o;
      idle(10);
      chk($sformatf("R11 hold code %0d", e), count_o, c0);
    end

    // R6 select / R7 gated
    wr(1, (2 << 3) | 5);
    wr(4, 1);
    for (int s = 0; s < 4; s++) begin
      wr(1, 16'((s << 6) | (2 << 3) | 5));
      idle(4);
      c0 = count_o;
      trig_i[(s + 1) % 4] = 1'b1;
      idle(6);
      trig_i = '0;
      idle(5);
      chk($sformatf("R6 unselected sel=%0d", s), count_o, c0);
      trig_i[s] = 1'b1;
      idle(5 + s);
      trig_i = '0;
      idle(5);
      chk($sformatf("R7 gated count sel=%0d", s), count_o, c0 + 16'(5 + s));
    end

    // R8 trigger start
    wr(0, 0);
    wr(1, (2 << 3) | 6);
    c0 = count_o;
    idle(5);
    chk("R8 idle before edge", count_o, c0);
    trig_i[0] = 1'b1;
    idle(2);
    trig_i[0] = 1'b0;
    idle(6);
    rd(0, d);
    chk("R8 run set", d[0], 1);
    chk("R8 counts without clear", count_o > c0, 1);

    // R9 reset mode
    wr(1, (1 << 6) | (2 << 3) | 4);
    idle(20);
    c1 = count_o;
    chk("R9 running before edge", c1 > 0, 1);
    trig_i[1] = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 counter cleared", count_o, 0);
    chk("R9 update output", trgo_o, 1);
    trig_i[1] = 1'b0;

    // R10 external clock
    wr(0, 1);
    wr(1, (3 << 6) | (2 << 3) | 7);
    wr(4, 1);
    idle(4);
    chk("R10 no edges", count_o, 0);
    for (int i = 0; i < 7; i++) begin
      trig_i[3] = 1'b1;
      idle(2);
      trig_i[3] = 1'b0;
      idle(2);
    end
    idle(6);
    chk("R10 edge count", count_o, 7);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule